// File: doc/BRIEF.md
# Real-time clock prescaler and update-window sequencer

This block sits between a 32.768 kHz timebase and the time-of-day counters of a real-time clock. A free-running prescaler counts reference cycles and emits a single-cycle pulse once per second; the time counters advance on that pulse. The same prescaler feeds two rate outputs, a periodic interrupt pulse and a 50% square wave, whose frequency software picks with a 4-bit rate code. A status flag warns software that the time counters are about to change, and stays up until the update has finished. While the flag is low, software can read the time without risk of a torn value.

Configuration comes from a 7-bit frequency-select value: a 3-bit timebase field and a 4-bit rate field. The timebase field either runs the prescaler, holds it in reset, or freezes it. When the prescaler leaves reset, its first second pulse comes half a second later, so software that sets the clock and then releases the prescaler sees the first update at a known time. The block returns the frequency-select value with the status flag as bit 7, as an 8-bit readback.

Top module: `rtc_divider_seq`

## Requirements
- R1: While rst_n is low, tick_o, per_o, sq_o and uip_o are 0, and freq_rd_o bit 7 is 0.
- R2: A timebase field (freq_sel_i[6:4]) of 3'b110 or 3'b111 holds the prescaler in reset. Two cycles after such a code appears, tick_o, per_o, sq_o and uip_o are 0 for as long as it stays. When the field then changes to 3'b010, the first tick_o comes 16384 cycles later: tick_o is high in the 16384th cycle after the first running cycle.
- R3: With the timebase field at 3'b010, tick_o is a one-cycle pulse repeating every 32768 cycles.
- R4: Any other timebase field value (for example 3'b000) freezes the prescaler. From the next cycle, tick_o, per_o and sq_o are 0. When running resumes, the count continues from where it stopped, so the next tick_o is late by the number of frozen cycles.
- R5: A rate field (freq_sel_i[3:0]) of 0 forces per_o and sq_o to 0 from the next cycle.
- R6: For a rate field n from 1 to 15, per_o is a one-cycle pulse every 2^(n-1) cycles, which is a rate of 65536>>n Hz. After release from prescaler reset, the pulse is high in running cycle j when (j-1) mod 2^(n-1) equals 2^(n-1)-1.
- R7: For n from 2 to 15, sq_o has period 2^(n-1) cycles with 50% duty, and is high in running cycle j when floor((j-1)/2^(n-2)) is odd. For n = 1, sq_o toggles every cycle.
- R8: uip_o rises 8 cycles before each tick_o and stays high through the tick. It falls 65 cycles after the tick: with a tick in cycle T, uip_o is high exactly in cycles T-8 through T+64.
- R9: freq_rd_o equals {uip_o, freq_sel_i} in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_sel_i | input | 7 | Timebase field [6:4] and rate field [3:0] |
| tick_o | output | 1 | One-second update pulse |
| per_o | output | 1 | Periodic interrupt pulse |
| sq_o | output | 1 | Square-wave output |
| uip_o | output | 1 | Update-in-progress flag |
| freq_rd_o | output | 8 | Readback {uip_o, freq_sel_i} |

## Verification
The assertions check the following on every cycle:
- the second pulse lasts one cycle, lands inside the update window and is preceded by a raised flag;
- the prescaler wraps to zero after its last count;
- a held or frozen prescaler and a zero rate code keep the outputs quiet.

Only the bench scenarios can show the following:
- the exact cycle counts: the half-second first tick, the 8-cycle lead and 65-cycle tail of the flag, and the one-second spacing;
- the per-rate pulse spacing and square-wave phase;
- the delay that a freeze adds to the next tick.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

  typedef enum logic [1:0] {
    DIV_RUN  = 2'd0,
    DIV_HOLD = 2'd1,
    DIV_STOP = 2'd2
  } div_mode_e;

  function automatic div_mode_e decode_div(input logic [2:0] field);
    if (field == 3'b010)       return DIV_RUN;
    else if (field[2:1] == 2'b11) return DIV_HOLD;
    else                       return DIV_STOP;
  endfunction

  // low-bit mask whose all-ones value marks one periodic pulse
  function automatic int unsigned rate_mask(input logic [3:0] n);
    if (n == 4'd0) return 0;
    return (32'd1 << (n - 4'd1)) - 32'd1;
  endfunction

  // prescaler bit that forms the square wave
  function automatic int unsigned sq_bit(input logic [3:0] n);
    if (n <= 4'd1) return 0;
    return 32'(n) - 2;
  endfunction

endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_div_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  div_mode_e        mode,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= HALF;
    end else begin
      case (mode)
        DIV_RUN:  cnt_q <= cnt_q + 1'b1;
        DIV_HOLD: cnt_q <= HALF;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (mode == DIV_RUN) && (cnt_q == CMAX);

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_o == '0)); // R3

endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap
  import rtc_div_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [3:0]       rate,
  input  logic [CNT_W-1:0] cnt,
  output logic             per_o,
  output logic             sq_o
);
  localparam int IDX_W = $clog2(CNT_W);

  logic [CNT_W-1:0] mask;
  logic [IDX_W-1:0] sq_idx;
  logic             active;
  logic             per_hit;
  logic             sq_next;

  always_comb begin
    mask   = CNT_W'(rate_mask(rate));
    sq_idx = (sq_bit(rate) > CNT_W - 1) ? IDX_W'(CNT_W - 1) : IDX_W'(sq_bit(rate));
    active = run && (rate != 4'd0);
    per_hit = active && ((cnt & mask) == mask);
    sq_next = active && cnt[sq_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_o <= 1'b0;
      sq_o  <= 1'b0;
    end else begin
      per_o <= per_hit;
      sq_o  <= sq_next;
    end
  end

  AST_RATE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 4'd0) |=> (!per_o && !sq_o)); // R5

endmodule

// File: rtl/rtc_uip_window.sv
module rtc_uip_window #(
  parameter int CNT_W = 15,
  parameter int LEAD  = 8,
  parameter int TRAIL = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  output logic             uip_o
);
  localparam logic [CNT_W-1:0] CMAX   = '1;
  localparam logic [CNT_W-1:0] WIN_LO = CMAX - CNT_W'(LEAD);
  localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(TRAIL - 2);

  logic in_window;

  assign in_window = (cnt >= WIN_LO) || (cnt <= WIN_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uip_o <= 1'b0;
    else        uip_o <= in_window;
  end

endmodule

// File: rtl/rtc_divider_seq.sv
module rtc_divider_seq
  import rtc_div_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int LEAD  = 8,
  parameter int TRAIL = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] freq_sel_i,
  output logic       tick_o,
  output logic       per_o,
  output logic       sq_o,
  output logic       uip_o,
  output logic [7:0] freq_rd_o
);
  div_mode_e        mode;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             run;

  assign mode = decode_div(freq_sel_i[6:4]);
  assign run  = (mode == DIV_RUN);

  rtc_div_chain #(.CNT_W(CNT_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cnt_o(cnt), .wrap_o(wrap)
  );

  rtc_rate_tap #(.CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(freq_sel_i[3:0]),
    .cnt(cnt), .per_o(per_o), .sq_o(sq_o)
  );

  rtc_uip_window #(.CNT_W(CNT_W), .LEAD(LEAD), .TRAIL(TRAIL)) u_uip (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .uip_o(uip_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_o <= 1'b0;
    else        tick_o <= wrap;
  end

  assign freq_rd_o = {uip_o, freq_sel_i};

  AST_TICK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> uip_o); // R8

  AST_FLAG_LEADS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_o) |-> $past(uip_o)); // R8

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R3

  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DIV_HOLD && $past(mode == DIV_HOLD)) |=>
      (!tick_o && !per_o && !sq_o && !uip_o)); // R2

  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DIV_STOP) |=> (!tick_o && !per_o && !sq_o)); // R4

endmodule

// File: tb/rtc_divider_seq_test.sv
module rtc_divider_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] sel;
  logic       tick, per, sq, uip;
  logic [7:0] rd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  rtc_divider_seq uut (
    .clk(clk), .rst_n(rst_n), .freq_sel_i(sel), .tick_o(tick),
    .per_o(per), .sq_o(sq), .uip_o(uip), .freq_rd_o(rd)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // hold prescaler in reset, then run; next posedge is running cycle 1
  task automatic release_with(input logic [3:0] n);
    sel = {3'b110, n};
    repeat (3) step();
    sel = {3'b010, n};
  endtask

  localparam int NVEC = 7;
  localparam logic [3:0] VEC_RATE [NVEC] = '{4'd1, 4'd2, 4'd3, 4'd5, 4'd8, 4'd12, 4'd15};
  localparam int WIN = 2048;

  initial begin
    int first_tick, second_tick, n_ticks, uip_rise, uip_fall;
    int rate_noise, rd_bad, hold_noise, stop_noise, late_tick;
    rst_n = 1'b0;
    sel   = 7'h60;
    repeat (3) step();
    chk(!tick && !per && !sq && !uip && !rd[7], "R1 reset outputs", {tick, per, sq, uip}, 0);
    rst_n = 1'b1;
    step();
    chk(!tick && !per && !sq && !uip, "R1 idle after reset", {tick, per, sq, uip}, 0);

    // vector table: per-rate pulse spacing and square-wave phase
    for (int v = 0; v < NVEC; v++) begin
      int per_bad, sq_bad, first_act, first_exp, period, half;
      logic [3:0] n;
      n = VEC_RATE[v];
      period = 1 << (n - 1);
      half = (n == 1) ? 1 : period / 2;
      per_bad = 0; sq_bad = 0; first_act = 0; first_exp = 0;
      release_with(n);
      for (int j = 1; j <= WIN; j++) begin
        bit ep, es;
        step();
        ep = (((j - 1) % period) == period - 1);
        es = (((j - 1) / half) % 2) == 1;
        if (per !== ep) begin
          if (per_bad == 0) begin first_act = per; first_exp = ep; end
          per_bad++;
        end
        if (sq !== es) sq_bad++;
      end
      chk(per_bad == 0, $sformatf("R6 pulse rate %0d mismatches", n), per_bad, 0);
      chk(sq_bad == 0, $sformatf("R7 square rate %0d mismatches", n), sq_bad, 0);
    end

    // first tick, spacing, update window, quiet rate 0, readback
    release_with(4'd0);
    first_tick = 0; second_tick = 0; n_ticks = 0; uip_rise = 0; uip_fall = 0;
    rate_noise = 0; rd_bad = 0;
    for (int j = 1; j <= 49160; j++) begin
      step();
      if (tick) begin
        n_ticks++;
        if (first_tick == 0) first_tick = j;
        else if (second_tick == 0) second_tick = j;
      end
      if (uip && uip_rise == 0) uip_rise = j;
      if (!uip && uip_rise != 0 && uip_fall == 0) uip_fall = j;
      if (per || sq) rate_noise++;
      if (rd !== {uip, sel}) rd_bad++;
    end
    chk(first_tick == 16384, "R2 first tick after release", first_tick, 16384);
    chk(second_tick == 16384 + 32768, "R3 tick spacing", second_tick, 49152);
    chk(n_ticks == 2, "R3 tick count (one cycle each)", n_ticks, 2);
    chk(uip_rise == 16376, "R8 uip rise", uip_rise, 16376);
    chk(uip_fall == 16449, "R8 uip fall", uip_fall, 16449);
    chk(rate_noise == 0, "R5 rate 0 quiet", rate_noise, 0);
    chk(rd_bad == 0, "R9 readback", rd_bad, 0);

    // second reset code holds everything quiet
    sel = 7'h75;
    hold_noise = 0;
    step(); step();
    for (int j = 0; j < 100; j++) begin
      if (tick || per || sq || uip) hold_noise++;
      step();
    end
    chk(hold_noise == 0, "R2 code 111 holds", hold_noise, 0);

    // freeze and resume
    release_with(4'd3);
    for (int j = 1; j <= 1000; j++) step();
    sel = 7'h03;
    stop_noise = 0;
    for (int j = 1001; j <= 1500; j++) begin
      step();
      if (tick || per || sq) stop_noise++;
    end
    sel = 7'h23;
    late_tick = 0;
    for (int j = 1501; j <= 17000; j++) begin
      step();
      if (tick && late_tick == 0) late_tick = j;
    end
    chk(stop_noise == 0, "R4 frozen outputs quiet", stop_noise, 0);
    chk(late_tick == 16884, "R4 tick delayed by freeze", late_tick, 16884);

    // rate changed to 0 while running
    sel = 7'h20;
    step();
    rate_noise = 0;
    for (int j = 0; j < 50; j++) begin
      if (per || sq) rate_noise++;
      step();
    end
    chk(rate_noise == 0, "R5 rate cleared while running", rate_noise, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule